// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of a serial EEPROM reached over a chip-select, serial-clock, data-in and data-out link. It holds a byte-wide array (512 bytes with the default 9 address bits). It decodes a framed command stream and carries out single-byte read, write and erase. It also handles whole-array erase and fill, and it sets and clears a write lock. Every serial input goes through a two-flop synchronizer on a fast system clock. The block acts on rising serial-clock edges and on the falling edge of chip select.

A command starts with a logic-1 start bit. A 2-bit opcode follows, then the address, then data when the command carries data. A read returns a zero placeholder bit, followed by the addressed byte. While chip select stays high, the read continues into the next addresses. Commands that change the array run as a self-timed programming cycle with a parameterised length in system clocks. The host can poll ready/busy on data out by raising chip select during that cycle.

Top module: `serial3_eeprom`

## Requirements
- R1: The start bit is the first data-in value of 1 sampled on a rising serial clock while chip select is high. Zero bits that come before it are ignored.
- R2: After reset the array is locked. Write, erase, erase-all and write-all have no effect until an enable command runs. A disable command locks the array again.
- R3: Opcode encodings are 10 read, 01 write, 11 erase, and 00 extended. In the extended group, the two address MSBs select 11 enable, 10 erase-all, 01 write-all and 00 disable. On a read, the edge of the last address bit puts a 0 on data out. The byte then follows MSB first, one bit per rising edge. Output enable is low during reset and whenever chip select is low.
- R4: While chip select stays high, a read continues with the next address. After the last address it wraps to address 0.
- R5: A write stores its data byte when chip select falls after all 20 clocks have been loaded.
- R6: A write or erase that is cut short by chip select falling is dropped, and no programming cycle starts.
- R7: Clock pulses after a complete command are ignored until chip select is cycled, including pulses with data-in high.
- R8: Erase sets one byte to FF. Erase-all sets every byte to FF. Write-all copies one data byte to every address.
- R9: During a programming cycle, raising chip select drives data out low while busy and high once ready. Polling may be repeated.
- R10: Commands issued while a programming cycle is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, active high |
| sclkIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in |
| doOut | output | 1 | Serial data out (read bits or ready/busy) |
| doOe | output | 1 | Output enable for data out; low means tri-state |

## Verification
The array is first cleared with erase-all. It then receives random address/data writes from a fixed seed, and each write is read back against a bench model. This separates correct address decode and bit order from aliasing or reversed shifting. Directed runs cover the following cases:
- leading zeros before the start bit;
- truncated commands and surplus clocks;
- the lock before enable and after disable;
- sequential reads across the top-of-array wrap.

These runs separate the execute-on-deselect rule and the lock from commands that apply too early or too freely. Status polling and a complete command sent during busy show whether the programming timer blocks new work and reports its state.

// File: rtl/s3e_pkg.sv
`timescale 1ns/1ps
package s3e_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL} progOp_e;
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DEC, S_DATA, S_RD, S_HOLD} ctlState_e;

  typedef struct packed {
    logic    shiftEn;
    logic    latchAddr;
    logic    loadRead;
    logic    readStep;
    logic    exec;
    progOp_e op;
    logic    rdActive;
    logic    statusShow;
    logic    busy;
  } ctlStrobe_t;
endpackage

// File: rtl/s3e_ctrl.sv
`timescale 1ns/1ps
module s3e_ctrl import s3e_pkg::*; #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkRise,
  input  logic       diS,
  input  logic [1:0] opBits,
  input  logic [1:0] extBits,
  output ctlStrobe_t st
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W + DATA_W);
  localparam int BC_W  = $clog2(PROG_CYCLES + 1);

  ctlState_e  state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  progOp_e    pend, pendN;
  logic       wen, wenN, arm, armN, execNow;
  logic [BC_W-1:0] busyCnt;
  logic       busy;

  assign busy = (busyCnt != '0);

  always_comb begin
    stateN = state; cntN = cnt; pendN = pend; wenN = wen; armN = arm;
    execNow = 1'b0;
    st.shiftEn = 1'b0; st.latchAddr = 1'b0; st.loadRead = 1'b0; st.readStep = 1'b0;
    unique case (state)
      S_IDLE: if (csS && sclkRise && diS && !busy) begin
        stateN = S_HDR; cntN = '0; armN = 1'b0;
      end
      S_HDR: if (!csS) stateN = S_IDLE;
        else if (sclkRise) begin
          st.shiftEn = 1'b1; cntN = cnt + 1'b1;
          if (cnt == CNT_W'(HDR_W - 1)) stateN = S_DEC;
        end
      S_DEC: begin
        st.latchAddr = 1'b1; cntN = '0; pendN = OP_NONE; stateN = S_HOLD;
        unique case (opBits)
          2'b10: begin st.loadRead = 1'b1; stateN = S_RD; end
          2'b01: begin pendN = OP_WRITE; stateN = S_DATA; end
          2'b11: pendN = OP_ERASE;
          default: unique case (extBits)
            2'b11: wenN = 1'b1;
            2'b10: pendN = OP_ERAL;
            2'b01: begin pendN = OP_WRAL; stateN = S_DATA; end
            default: wenN = 1'b0;
          endcase
        endcase
      end
      S_DATA: if (!csS) stateN = S_IDLE;
        else if (sclkRise) begin
          st.shiftEn = 1'b1; cntN = cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W - 1)) stateN = S_HOLD;
        end
      S_RD: if (!csS) stateN = S_IDLE;
        else if (sclkRise) st.readStep = 1'b1;
      default: if (!csS) begin
        stateN = S_IDLE;
        if (pend != OP_NONE && wen) begin execNow = 1'b1; armN = 1'b1; end
      end
    endcase
    st.exec       = execNow;
    st.op         = pend;
    st.rdActive   = (state == S_RD);
    st.statusShow = arm;
    st.busy       = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; pend <= OP_NONE;
      wen <= 1'b0; arm <= 1'b0; busyCnt <= '0;
    end else begin
      state <= stateN; cnt <= cntN; pend <= pendN; wen <= wenN; arm <= armN;
      if (execNow) busyCnt <= BC_W'(PROG_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/s3e_data.sv
`timescale 1ns/1ps
module s3e_data import s3e_pkg::*; #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       diS,
  input  ctlStrobe_t st,
  output logic [1:0] opBits,
  output logic [1:0] extBits,
  output logic       doOut,
  output logic       doOe
);
  localparam int HDR_W   = 2 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int BI_W    = $clog2(DATA_W);

  logic [FRAME_W-1:0] sr;
  logic [ADDR_W-1:0]  addrQ, rdAddr;
  logic [BI_W-1:0]    bitIdx;
  logic               doQ;
  logic [DATA_W-1:0]  mem [DEPTH];

  assign opBits  = sr[HDR_W-1 -: 2];
  assign extBits = sr[ADDR_W-1 -: 2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr <= '0; addrQ <= '0; rdAddr <= '0; bitIdx <= '0; doQ <= 1'b0;
    end else begin
      if (st.shiftEn)   sr <= {sr[FRAME_W-2:0], diS};
      if (st.latchAddr) addrQ <= sr[ADDR_W-1:0];
      if (st.loadRead) begin
        rdAddr <= sr[ADDR_W-1:0]; bitIdx <= '0; doQ <= 1'b0;
      end else if (st.readStep) begin
        doQ <= mem[rdAddr][BI_W'(DATA_W - 1) - bitIdx];
        if (bitIdx == BI_W'(DATA_W - 1)) begin
          bitIdx <= '0; rdAddr <= rdAddr + 1'b1;
        end else bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // Array storage: no reset, as in a non-volatile part.
  always_ff @(posedge clk) begin
    if (st.exec) begin
      unique case (st.op)
        OP_WRITE: mem[addrQ] <= sr[DATA_W-1:0];
        OP_ERASE: mem[addrQ] <= '1;
        OP_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        OP_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= sr[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  assign doOe  = csS && (st.rdActive || st.statusShow);
  assign doOut = doOe && (st.rdActive ? doQ : !st.busy);
endmodule

// File: rtl/serial3_eeprom.sv
`timescale 1ns/1ps
module serial3_eeprom import s3e_pkg::*; #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);
  logic [1:0] csPipe, sclkPipe, diPipe;
  logic       sclkQ;
  logic       csS, sclkS, diS, sclkRise;
  logic [1:0] opBits, extBits;
  ctlStrobe_t st;
  logic       stRd, stBusy, stExec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe <= '0; sclkPipe <= '0; diPipe <= '0; sclkQ <= 1'b0;
    end else begin
      csPipe   <= {csPipe[0], csIn};
      sclkPipe <= {sclkPipe[0], sclkIn};
      diPipe   <= {diPipe[0], diIn};
      sclkQ    <= sclkPipe[1];
    end
  end

  assign csS      = csPipe[1];
  assign sclkS    = sclkPipe[1];
  assign diS      = diPipe[1];
  assign sclkRise = sclkS && !sclkQ;

  s3e_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .sclkRise(sclkRise), .diS(diS),
    .opBits(opBits), .extBits(extBits), .st(st));

  s3e_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .csS(csS), .diS(diS), .st(st),
    .opBits(opBits), .extBits(extBits), .doOut(doOut), .doOe(doOe));

  assign stRd   = st.rdActive;
  assign stBusy = st.busy;
  assign stExec = st.exec;
endmodule

// File: rtl/serial3_eeprom_chk.sv
`timescale 1ns/1ps
module serial3_eeprom_chk (
  input logic clk,
  input logic rstN,
  input logic csIn,
  input logic doOut,
  input logic doOe,
  input logic stRd,
  input logic stBusy,
  input logic stExec
);
  // R3
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stRd) |-> !doOut);

  // R3
  oe_off_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csIn && !$past(csIn) && !$past(csIn, 2) && !$past(csIn, 3)) |-> !doOe);

  // R9
  exec_then_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stExec |=> stBusy);

  // R10
  no_read_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stBusy |-> !stRd);
endmodule

bind serial3_eeprom serial3_eeprom_chk chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .doOut(doOut), .doOe(doOe),
  .stRd(stRd), .stBusy(stBusy), .stExec(stExec));

// File: tb/serial3_eeprom_test.sv
`timescale 1ns/1ps
module serial3_eeprom_test;
  localparam int PROG  = 300;
  localparam int DEPTH = 512;

  logic clk = 1'b0, rstN = 1'b0, csIn = 1'b0, sclkIn = 1'b0, diIn = 1'b0;
  logic doOut, doOe;
  logic obsDo, obsOe;
  int   nTests = 0, nFail = 0;
  logic [7:0] model [DEPTH];
  bit   wenModel = 1'b0;

  serial3_eeprom #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .diIn(diIn),
    .doOut(doOut), .doOe(doOe));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] expectAt(input int a);
    return model[a % DEPTH];
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitClk(input logic b);
    diIn = b;
    repeat (3) @(negedge clk);
    sclkIn = 1'b1;
    repeat (6) @(negedge clk);
    obsDo = doOut; obsOe = doOe;
    sclkIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitClk(v[i]);
  endtask

  task automatic csUp();
    csIn = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic csDown();
    sclkIn = 1'b0; csIn = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [8:0] a);
    bitClk(1'b1); sendBits({30'd0, op}, 2); sendBits({23'd0, a}, 9);
  endtask

  task automatic progWait();
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic setLock(input bit enable);
    csUp(); header(2'b00, enable ? 9'b110000000 : 9'b000000000); csDown();
    wenModel = enable;
  endtask

  task automatic writeByte(input int a, input logic [7:0] d);
    csUp(); header(2'b01, 9'(a)); sendBits({24'd0, d}, 8); csDown(); progWait();
    if (wenModel) model[a] = d;
  endtask

  task automatic readCheck(input string req, input int a, input int n);
    logic [7:0] got;
    csUp(); header(2'b10, 9'(a));
    checkEq({req, " dummy bit"}, int'(obsDo), 0);
    checkEq({req, " oe during read"}, int'(obsOe), 1);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin bitClk(1'b0); got[b] = obsDo; end
      checkEq({req, " read data"}, int'(got), int'(expectAt(a + k)));
    end
    csDown();
    checkEq({req, " oe after deselect"}, int'(doOe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    checkEq("R3 reset oe", int'(doOe), 0);
    checkEq("R3 reset do", int'(doOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Clear the array: enable, erase-all (R8)
    setLock(1'b1);
    csUp(); header(2'b00, 9'b100000000); csDown(); progWait();
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    readCheck("R8 erase-all", 0, 2);
    readCheck("R8 erase-all top", 511, 1);

    // R2: locked after disable
    setLock(1'b0);
    writeByte(5, 8'h12);
    readCheck("R2 locked write", 5, 1);
    csUp(); header(2'b00, 9'b010000000); sendBits(32'h33, 8); csDown(); progWait();
    readCheck("R2 locked write-all", 100, 1);
    setLock(1'b1);

    // R5: random writes with readback
    for (int n = 0; n < 16; n++) begin
      int a; logic [7:0] d;
      a = int'($urandom % DEPTH); d = 8'($urandom);
      writeByte(a, d);
      readCheck("R5 random write", a, 1);
    end

    // R4: sequential read and wrap
    writeByte(510, 8'hA5); writeByte(511, 8'h3C); writeByte(0, 8'h81); writeByte(1, 8'h7E);
    readCheck("R4 sequential wrap", 510, 4);
    readCheck("R4 sequential", int'($urandom % 500), 3);

    // R1: leading zeros before the start bit
    csUp(); sendBits(32'b000, 3); header(2'b01, 9'd77); sendBits(32'hC3, 8); csDown(); progWait();
    model[77] = 8'hC3;
    readCheck("R1 leading zeros", 77, 1);

    // R6: truncated write is dropped, no busy status
    csUp(); header(2'b01, 9'd77); sendBits(32'h1F, 5); csDown();
    csUp();
    checkEq("R6 no status after truncated", int'(doOe), 0);
    csDown(); progWait();
    readCheck("R6 truncated write", 77, 1);

    // R7: surplus clocks after a complete write and erase
    csUp(); header(2'b01, 9'd200); sendBits(32'h5A, 8); sendBits(32'b1111, 4); csDown(); progWait();
    model[200] = 8'h5A;
    readCheck("R7 extra bits write", 200, 1);
    writeByte(201, 8'h42);
    csUp(); header(2'b11, 9'd200); sendBits(32'b10110, 5); csDown(); progWait();
    model[200] = 8'hFF;
    readCheck("R7 extra bits erase", 200, 2);

    // R8: single erase and write-all
    csUp(); header(2'b11, 9'd201); csDown(); progWait();
    model[201] = 8'hFF;
    readCheck("R8 erase", 201, 1);
    csUp(); header(2'b00, 9'b010000000); sendBits(32'h96, 8); csDown(); progWait();
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h96;
    readCheck("R8 write-all", 0, 2);
    readCheck("R8 write-all", int'($urandom % DEPTH), 1);

    // R9: status polling during programming
    csUp(); header(2'b01, 9'd9); sendBits(32'h24, 8); csDown();
    model[9] = 8'h24;
    csUp();
    checkEq("R9 poll oe", int'(doOe), 1);
    checkEq("R9 poll busy", int'(doOut), 0);
    csDown();
    checkEq("R9 oe off between polls", int'(doOe), 0);
    csUp();
    checkEq("R9 second poll busy", int'(doOut), 0);
    repeat (PROG) @(negedge clk);
    checkEq("R9 poll ready", int'(doOut), 1);
    csDown();
    readCheck("R9 data after poll", 9, 1);

    // R10: command during busy is ignored
    csUp(); header(2'b01, 9'd30); sendBits(32'h11, 8); csDown();
    model[30] = 8'h11;
    csUp(); header(2'b01, 9'd31); sendBits(32'hEE, 8); csDown(); progWait();
    readCheck("R10 busy ignored", 31, 1);
    readCheck("R10 first write kept", 30, 1);

    // R2: erase while locked has no effect
    setLock(1'b0);
    csUp(); header(2'b11, 9'd30); csDown(); progWait();
    readCheck("R2 locked erase", 30, 1);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule